// File: doc/BRIEF.md
# Video Core Two-Wire Register Interface with Timed Commit

This block is the two-wire (I2C) slave through which a host programs the control registers of a video processing core. It answers to the 7-bit device address 1011110b. The address byte with the direction bit clear (BCh) is for writing and the address byte with the direction bit set (BDh) is for reading. The block supports three access forms: a write with a subaddress, a read that sets a subaddress and then turns the bus around with a repeated start, and a continuous read that skips the subaddress phase. A single internal pointer advances after every data byte in all three forms.

Bytes the host writes go into a staging bank and do not reach the core at once. The host writes any byte to subaddress FFh to arm a store. The staging values are then copied into the active bank, which drives the core, at the next video timing event. Each register belongs to one of two groups, chosen by a per-register parameter bit. One group copies on the next vertical sync pulse. The other copies on the next pulse that marks the start of an output cycle (four fields in interlaced 100/120 Hz operation, two frames in progressive 50/60 Hz operation). This keeps a half-programmed setting from ever reaching the picture.

The SCL and SDA pins pass through a synchronizer and a glitch filter clocked by the system clock. The block drives SDA through an open-drain enable only. The filter leaves enough margin for both 100 kHz and 400 kHz bus rates at a system clock in the tens of MHz.

Top module: `vid_i2c_regif`

## Requirements
- R1: The block acknowledges only the address bytes BCh and BDh. After any other address byte it leaves SDA released for the acknowledge bit and for the rest of the transaction.
- R2: In a write transaction, the first byte after the address is loaded into the pointer. Each following data byte is acknowledged, stored into staging register [pointer], and then the pointer advances.
- R3: After a subaddress write, a repeated start, and BDh, the block transmits staging register [pointer] MSB first and advances the pointer after each byte. It keeps sending while the master acknowledges, and releases SDA after a not-acknowledge.
- R4: A continuous read (start, BDh) begins at subaddress 00h after reset. Otherwise it begins at the pointer left by the previous transaction.
- R5: After subaddress FEh, and after FFh, the pointer moves to 00h. Writes to subaddresses from NUM_REGS up to FEh are ignored, and reads from subaddresses NUM_REGS through FFh return 00h.
- R6: A data byte written to subaddress FFh changes no register and arms a store for both groups.
- R7: Active registers change only on a cycle in which vsync_i or cyc_start_i is high, and never before a store has been armed.
- R8: When a store is armed, the registers whose VSYNC_MASK bit is 1 take their staging values on the next vsync_i pulse, and the registers whose bit is 0 take theirs on the next cyc_start_i pulse. Each group's pending flag clears separately after it commits, so a later pulse with no new store changes nothing.
- R9: After reset, staging and active register i both hold {i[3:0], ~i[3:0]}, and sda_oe_o is 0.
- R10: The block releases SDA on every stop condition, on every start condition, and whenever it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level |
| vsync_i | input | 1 | Vertical sync pulse, one clk cycle, in clk domain |
| cyc_start_i | input | 1 | Output-cycle start pulse, one clk cycle, in clk domain |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| act_regs_o | output | 8*NUM_REGS | Active register bank, register i at bits [8i+7:8i] |

## Verification
On every cycle, the assertions check that the active bank holds its value when neither timing pulse is present. They also check that a pulse arriving with a store pending copies the staging value into the register of the matching group. The same cycle-by-cycle checks cover the SDA release on stop and in idle, and the pointer wrap from FEh. Only the bench scenarios can show the bus-level behaviour: acknowledge versus no acknowledge by address, the byte order of write and read transactions, where a continuous read resumes, and that a store commits one group on one pulse type and then stays cleared.

// File: rtl/vri_pkg.sv
package vri_pkg;

    localparam logic [6:0] DEV_ADDR  = 7'b1011110;
    localparam logic [7:0] STORE_SUB = 8'hFF;
    localparam logic [7:0] LAST_SUB  = 8'hFE;

    typedef enum logic [3:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_ACK,
        BS_SUB,
        BS_SUB_ACK,
        BS_WDATA,
        BS_WDATA_ACK,
        BS_RDATA,
        BS_RDATA_ACK
    } bus_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [7:0] ptr_next(input logic [7:0] p);
        return (p >= LAST_SUB) ? 8'h00 : p + 8'd1;
    endfunction

    function automatic logic [7:0] reset_val(input logic [7:0] idx);
        return {idx[3:0], ~idx[3:0]};
    endfunction

endpackage

// File: rtl/vri_line_filter.sv
module vri_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            cnt_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (sync_q[SYNC_STAGES-1] != clean_q) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    clean_q <= sync_q[SYNC_STAGES-1];
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign clean_o = clean_q;

endmodule

// File: rtl/vri_bus_engine.sv
module vri_bus_engine
    import vri_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] rd_data_i,
    output logic [7:0] rd_addr_o,
    output wr_req_t    wr_o,
    output logic       sda_oe_o
);
    bus_state_e state_q;
    logic       scl_q, sda_q;
    logic [3:0] bit_cnt_q;
    logic [7:0] shreg_q;
    logic [7:0] ptr_q;
    logic       rw_q;
    logic       ack_q;
    logic       oe_q;
    wr_req_t    wr_q;

    logic start_c, stop_c, rise_c, fall_c;
    assign start_c = scl_q & scl_f & sda_q & ~sda_f;
    assign stop_c  = scl_q & scl_f & ~sda_q & sda_f;
    assign rise_c  = ~scl_q & scl_f;
    assign fall_c  = scl_q & ~scl_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= BS_IDLE;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            ptr_q     <= '0;
            rw_q      <= 1'b0;
            ack_q     <= 1'b0;
            oe_q      <= 1'b0;
            wr_q      <= '0;
        end else begin
            scl_q   <= scl_f;
            sda_q   <= sda_f;
            wr_q.en <= 1'b0;
            if (start_c) begin
                state_q   <= BS_ADDR;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
            end else if (stop_c) begin
                state_q <= BS_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    BS_ADDR, BS_SUB, BS_WDATA: begin
                        if (rise_c && bit_cnt_q < 4'd8) begin
                            shreg_q   <= {shreg_q[6:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (fall_c && bit_cnt_q == 4'd8) begin
                            bit_cnt_q <= '0;
                            if (state_q == BS_ADDR) begin
                                if (shreg_q[7:1] == DEV_ADDR) begin
                                    rw_q    <= shreg_q[0];
                                    oe_q    <= 1'b1;
                                    state_q <= BS_ADDR_ACK;
                                end else begin
                                    oe_q    <= 1'b0;
                                    state_q <= BS_IDLE;
                                end
                            end else if (state_q == BS_SUB) begin
                                ptr_q   <= shreg_q;
                                oe_q    <= 1'b1;
                                state_q <= BS_SUB_ACK;
                            end else begin
                                wr_q.en   <= 1'b1;
                                wr_q.addr <= ptr_q;
                                wr_q.data <= shreg_q;
                                ptr_q     <= ptr_next(ptr_q);
                                oe_q      <= 1'b1;
                                state_q   <= BS_WDATA_ACK;
                            end
                        end
                    end
                    BS_ADDR_ACK: begin
                        if (fall_c) begin
                            if (rw_q) begin
                                shreg_q   <= rd_data_i;
                                oe_q      <= ~rd_data_i[7];
                                bit_cnt_q <= 4'd1;
                                state_q   <= BS_RDATA;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= BS_SUB;
                            end
                        end
                    end
                    BS_SUB_ACK, BS_WDATA_ACK: begin
                        if (fall_c) begin
                            oe_q    <= 1'b0;
                            state_q <= BS_WDATA;
                        end
                    end
                    BS_RDATA: begin
                        if (fall_c) begin
                            if (bit_cnt_q == 4'd8) begin
                                oe_q      <= 1'b0;
                                bit_cnt_q <= '0;
                                ptr_q     <= ptr_next(ptr_q);
                                state_q   <= BS_RDATA_ACK;
                            end else begin
                                oe_q      <= ~shreg_q[6];
                                shreg_q   <= {shreg_q[6:0], 1'b0};
                                bit_cnt_q <= bit_cnt_q + 4'd1;
                            end
                        end
                    end
                    BS_RDATA_ACK: begin
                        if (rise_c) begin
                            ack_q <= ~sda_f;
                        end else if (fall_c) begin
                            if (ack_q) begin
                                shreg_q   <= rd_data_i;
                                oe_q      <= ~rd_data_i[7];
                                bit_cnt_q <= 4'd1;
                                state_q   <= BS_RDATA;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= BS_IDLE;
                            end
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign rd_addr_o = ptr_q;
    assign wr_o      = wr_q;
    assign sda_oe_o  = oe_q;

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == BS_IDLE) |-> !oe_q);  // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> !oe_q);  // R10
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
        start_c |=> !oe_q);  // R10
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_q.en && wr_q.addr == LAST_SUB) |-> (ptr_q == 8'h00));  // R5

endmodule

// File: rtl/vri_reg_bank.sv
module vri_reg_bank
    import vri_pkg::*;
#(
    parameter int                  NUM_REGS   = 16,
    parameter logic [NUM_REGS-1:0] VSYNC_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr_i,
    input  logic [7:0]              rd_addr_i,
    input  logic                    vsync_i,
    input  logic                    cyc_i,
    output logic [7:0]              rd_data_o,
    output logic [NUM_REGS*8-1:0]   act_o
);
    localparam int         IDXW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0] NREG9 = 9'(NUM_REGS);

    logic [7:0] stage_q  [NUM_REGS];
    logic [7:0] active_q [NUM_REGS];
    logic       pend_v_q, pend_c_q;
    logic       arm_c;

    assign arm_c = wr_i.en && (wr_i.addr == STORE_SUB);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q <= 1'b0;
            pend_c_q <= 1'b0;
        end else begin
            pend_v_q <= arm_c | (pend_v_q & ~vsync_i);
            pend_c_q <= arm_c | (pend_c_q & ~cyc_i);
        end
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] IDX = 8'(i);
        logic commit_c;

        if (VSYNC_MASK[i]) begin : g_vgrp
            assign commit_c = pend_v_q & vsync_i;
            AST_V_COMMIT: assert property (@(posedge clk) disable iff (rst)
                (pend_v_q && vsync_i) |=> (active_q[i] == $past(stage_q[i])));  // R8
        end else begin : g_cgrp
            assign commit_c = pend_c_q & cyc_i;
            AST_C_COMMIT: assert property (@(posedge clk) disable iff (rst)
                (pend_c_q && cyc_i) |=> (active_q[i] == $past(stage_q[i])));  // R8
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i]  <= reset_val(IDX);
                active_q[i] <= reset_val(IDX);
            end else begin
                if (wr_i.en && wr_i.addr == IDX) begin
                    stage_q[i] <= wr_i.data;
                end
                if (commit_c) begin
                    active_q[i] <= stage_q[i];
                end
            end
        end

        assign act_o[8*i +: 8] = active_q[i];

        AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!vsync_i && !cyc_i) |=> $stable(active_q[i]));  // R7
    end

    always_comb begin
        if ({1'b0, rd_addr_i} < NREG9) begin
            rd_data_o = stage_q[rd_addr_i[IDXW-1:0]];
        end else begin
            rd_data_o = 8'h00;
        end
    end

endmodule

// File: rtl/vid_i2c_regif.sv
module vid_i2c_regif
    import vri_pkg::*;
#(
    parameter int                  NUM_REGS    = 16,
    parameter logic [NUM_REGS-1:0] VSYNC_MASK  = 16'h00FF,
    parameter int                  SYNC_STAGES = 2,
    parameter int                  FILT_LEN    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  vsync_i,
    input  logic                  cyc_start_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] act_regs_o
);
    logic       scl_f, sda_f;
    logic [7:0] rd_addr, rd_data;
    wr_req_t    wr_req;

    vri_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst(rst), .raw_i(scl_i), .clean_o(scl_f)
    );

    vri_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst(rst), .raw_i(sda_i), .clean_o(sda_f)
    );

    vri_bus_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_o      (wr_req),
        .sda_oe_o  (sda_oe_o)
    );

    vri_reg_bank #(.NUM_REGS(NUM_REGS), .VSYNC_MASK(VSYNC_MASK)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_req),
        .rd_addr_i (rd_addr),
        .vsync_i   (vsync_i),
        .cyc_i     (cyc_start_i),
        .rd_data_o (rd_data),
        .act_o     (act_regs_o)
    );

endmodule

// File: tb/vid_i2c_regif_test.sv
module vid_i2c_regif_test;

    localparam int Q = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         vsync = 1'b0;
    logic         cyc = 1'b0;
    logic         sda_oe;
    logic [127:0] act;
    logic         sda_line;
    logic         done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    vid_i2c_regif uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .vsync_i(vsync), .cyc_start_i(cyc),
        .sda_oe_o(sda_oe), .act_regs_o(act)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] act_reg(input int i);
        return act[8*i +: 8];
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wn(Q);
        scl_m = 1'b1; wn(Q);
        sda_m = 1'b0; wn(Q);
        scl_m = 1'b0; wn(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wn(Q);
        scl_m = 1'b1; wn(Q);
        sda_m = 1'b1; wn(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wn(Q);
        scl_m = 1'b1; wn(2*Q);
        scl_m = 1'b0; wn(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wn(Q);
        scl_m = 1'b1; wn(Q);
        b = sda_line; wn(Q);
        scl_m = 1'b0; wn(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic write_regs(input logic [7:0] sub, input int n);
        logic ack;
        bus_start();
        send_byte(8'hBC, ack); chk("R1 write addr ack", ack, 1);
        send_byte(sub, ack);   chk("R2 subaddr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk("R2 data ack", ack, 1);
        end
        bus_stop();
        wn(4);
        chk("R10 released after stop", sda_oe, 0);
    endtask

    task automatic read_sub(input logic [7:0] sub, input int n);
        logic ack;
        bus_start();
        send_byte(8'hBC, ack); chk("R3 addr ack", ack, 1);
        send_byte(sub, ack);   chk("R3 subaddr ack", ack, 1);
        bus_start();
        send_byte(8'hBD, ack); chk("R3 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        wn(4);
        chk("R3 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic cont_read(input int n);
        logic ack;
        bus_start();
        send_byte(8'hBD, ack); chk("R4 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        bus_stop();
    endtask

    task automatic pulse_vsync();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        wn(1);
    endtask

    task automatic pulse_cyc();
        @(negedge clk) cyc = 1'b1;
        @(negedge clk) cyc = 1'b0;
        wn(1);
    endtask

    task automatic t_reset();
        chk("R9 sda_oe reset", sda_oe, 0);
        chk("R9 reg0 reset", act_reg(0), 8'h0F);
        chk("R9 reg5 reset", act_reg(5), 8'h5A);
        chk("R9 reg15 reset", act_reg(15), 8'hF0);
    endtask

    task automatic t_cont_from_reset();
        cont_read(3);
        chk("R4 cont read byte0", rbuf[0], 8'h0F);
        chk("R4 cont read byte1", rbuf[1], 8'h1E);
        chk("R4 cont read byte2", rbuf[2], 8'h2D);
    endtask

    task automatic t_bad_addr();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack);
        chk("R1 foreign addr nack", ack, 0);
        send_byte(8'h00, ack);
        chk("R1 foreign stays silent", ack, 0);
        bus_stop();
    endtask

    task automatic t_write_read();
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        write_regs(8'h02, 3);
        read_sub(8'h02, 3);
        chk("R3 read byte0", rbuf[0], 8'hAA);
        chk("R3 read byte1", rbuf[1], 8'hBB);
        chk("R3 read byte2", rbuf[2], 8'hCC);
        chk("R7 active reg2 untouched", act_reg(2), 8'h2D);
        cont_read(1);
        chk("R4 cont read resumes", rbuf[0], 8'h5A);
    endtask

    task automatic t_store_commit();
        wbuf[0] = 8'h99;
        write_regs(8'h09, 1);
        wbuf[0] = 8'h00;
        write_regs(8'hFF, 1);
        read_sub(8'hFF, 1);
        chk("R6 FF reads zero", rbuf[0], 8'h00);
        chk("R7 reg2 before event", act_reg(2), 8'h2D);
        chk("R7 reg9 before event", act_reg(9), 8'h96);
        pulse_vsync();
        chk("R8 vsync reg2", act_reg(2), 8'hAA);
        chk("R8 vsync reg4", act_reg(4), 8'hCC);
        chk("R8 vsync leaves reg9", act_reg(9), 8'h96);
        pulse_cyc();
        chk("R8 cyc reg9", act_reg(9), 8'h99);
        chk("R6 reg0 untouched by FF", act_reg(0), 8'h0F);
    endtask

    task automatic t_pend_clear();
        wbuf[0] = 8'h33;
        write_regs(8'h03, 1);
        pulse_vsync();
        pulse_cyc();
        chk("R8 no second vsync commit", act_reg(3), 8'hBB);
        chk("R7 no commit without store", act_reg(9), 8'h99);
    endtask

    task automatic t_wrap();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_regs(8'hFE, 2);
        read_sub(8'h00, 1);
        chk("R5 wrap writes reg0", rbuf[0], 8'h22);
        read_sub(8'h20, 1);
        chk("R5 out of range reads zero", rbuf[0], 8'h00);
    endtask

    task automatic t_group_split();
        wbuf[0] = 8'h00;
        write_regs(8'hFF, 1);
        pulse_cyc();
        chk("R8 cyc leaves vsync group", act_reg(0), 8'h0F);
        pulse_vsync();
        chk("R8 vsync reg0 after split", act_reg(0), 8'h22);
        chk("R8 vsync reg3 after split", act_reg(3), 8'h33);
    endtask

    initial begin
        wn(5);
        rst = 1'b0;
        wn(5);
        t_reset();
        t_cont_from_reset();
        t_bad_addr();
        t_write_read();
        t_store_commit();
        t_pend_clear();
        t_wrap();
        t_group_split();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule